// File: doc/BRIEF.md
# Two-Wire Serial Memory Slave

This block is the slave end of a two-wire serial memory. It holds a byte array in registers. It watches the clock line and the data line by sampling them on a fast system clock. It pulls the data line low through an open-drain enable output.

A transaction opens with a start condition, followed by a select byte. The block acknowledges the select byte only when its type field and its strapped chip-enable bits match. A write carries a word-address byte, then data bytes. Those data bytes wait in a small pending buffer. They reach the array only when a stop closes the write, and the stop then opens an internal write cycle of fixed length. A read shifts out bytes from the address pointer for as long as the master keeps acknowledging.

On larger capacities, the low chip-enable positions of the select byte stop taking part in the match and carry the high address bits instead.

Top module: `twi_mem_slave`

## Requirements
- R1: With no start condition seen since reset or since the last stop, the block never pulls the data line low, whatever is clocked on the bus. A start is the data line falling while the clock line is high.
- R2: A stop is the data line rising while the clock line is high. It ends any transaction, and the block answers nothing until the next start.
- R3: The select byte is received most significant bit first. Bits 7..4 must be 1010. Bits 3, 2 and 1 are compared with chip-enable inputs 2, 1 and 0. Bit 0 is 1 for read and 0 for write. On a match the block holds the data line low for the whole 9th clock.
- R4: When the select byte does not match, the block gives no acknowledge. It then ignores all further bytes until a new start.
- R5: The block changes its data-line drive only while the clock line is low.
- R6: After an acknowledged write select, the next byte sets the low 8 bits of the address pointer. Each later byte is acknowledged and queued for the pointer address. The pointer then increments and wraps within the array.
- R7: Queued data reaches the array only when a stop follows at least one data byte. A repeated start, or a stop with no data byte, discards the queue and starts no write cycle.
- R8: The queue holds BUF_DEPTH bytes. Data bytes beyond that are still acknowledged and still advance the pointer, but they are dropped.
- R9: The stop that commits a write raises `busy` for exactly WRITE_CYCLES system clocks. During that time the block ignores starts and gives no acknowledge.
- R10: On a read, the block drives the byte at the pointer most significant bit first and releases the line for the 9th clock. A master acknowledge (data low on the 9th rising edge) increments the pointer and sends the next byte. A no-acknowledge leaves the pointer unchanged and releases the bus until a stop or start.
- R11: For MEM_BYTES of 512, 1024 and 2048, select bits 1, 1..2 and 1..3 respectively supply address bits 8 and up, and they take no part in the match.
- R12: After reset, `sdaOe` and `busy` are low and every array byte reads as 0x00.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock used to oversample the bus |
| rstN | input | 1 | Active-low synchronous reset |
| sclIn | input | 1 | Bus clock line level |
| sdaIn | input | 1 | Bus data line level |
| chipEn | input | 3 | Strapped chip-enable bits (bit 2 compared with select bit 3) |
| sdaOe | output | 1 | High pulls the data line low |
| busy | output | 1 | Internal write cycle in progress |

## Verification
Some properties are checked on every cycle. The data-line drive only moves while the sampled clock line is low. The drive stays released in standby and throughout the write cycle. The write cycle lasts exactly its configured length and only ever begins right after a stop.

Other behaviours only the bench scenarios can show: select decoding, queue overflow, discard on a repeated start, pointer wrap, pointer behaviour after an acknowledge versus a no-acknowledge, and the chip-enable bit serving as an address bit. These are shown by comparing bytes read back through the bus against a bench model of the array, with two differently sized slaves on one shared bus.

// File: rtl/twi_mem_pkg.sv
package twi_mem_pkg;

  typedef enum logic [2:0] {
    PH_IDLE,
    PH_SEL,
    PH_ADDR,
    PH_WDATA,
    PH_RDATA,
    PH_HALT,
    PH_BUSY
  } phase_t;

  // Strobes from control to datapath, one cycle each
  typedef struct packed {
    logic shiftIn;
    logic sdaBit;
    logic loadHi;
    logic loadLow;
    logic bufPush;
    logic bufClear;
    logic commit;
    logic loadTx;
    logic shiftOut;
    logic nextTx;
  } strobe_t;

endpackage

// File: rtl/twi_mem_ctrl.sv
module twi_mem_ctrl
  import twi_mem_pkg::*;
#(
  parameter int WRITE_CYCLES = 400
) (
  input  logic    clk,
  input  logic    rstN,
  input  logic    sclIn,
  input  logic    sdaIn,
  input  logic    selMatch,
  input  logic    selRead,
  input  logic    txMsb,
  input  logic    bufHas,
  output strobe_t stb,
  output logic    sdaOe,
  output logic    busy
);

  localparam int CW = $clog2(WRITE_CYCLES + 1);

  logic [1:0] sclSync, sdaSync;
  logic sclLvl, sdaLvl, sclPrev, sdaPrev;
  logic startEv, stopEv, sclRise, sclFall;

  phase_t phase, phaseN;
  logic [3:0] bitCnt, bitCntN;
  logic ackDrive, ackN, txActive, txN;
  logic [CW-1:0] busyCnt, busyCntN;

  assign sclLvl = sclSync[1];
  assign sdaLvl = sdaSync[1];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclSync <= 2'b11;
      sdaSync <= 2'b11;
      sclPrev <= 1'b1;
      sdaPrev <= 1'b1;
    end else begin
      sclSync <= {sclSync[0], sclIn};
      sdaSync <= {sdaSync[0], sdaIn};
      sclPrev <= sclLvl;
      sdaPrev <= sdaLvl;
    end
  end

  assign startEv = sclLvl & sclPrev & sdaPrev & ~sdaLvl;
  assign stopEv  = sclLvl & sclPrev & ~sdaPrev & sdaLvl;
  assign sclRise = sclLvl & ~sclPrev;
  assign sclFall = ~sclLvl & sclPrev;

  always_comb begin
    phaseN   = phase;
    bitCntN  = bitCnt;
    ackN     = ackDrive;
    txN      = txActive;
    busyCntN = busyCnt;
    stb        = '0;
    stb.sdaBit = sdaLvl;
    if (phase == PH_BUSY) begin
      if (busyCnt == '0) phaseN = PH_IDLE;
      else busyCntN = busyCnt - 1'b1;
    end else if (stopEv) begin
      ackN    = 1'b0;
      txN     = 1'b0;
      bitCntN = '0;
      if (phase == PH_WDATA && bufHas) begin
        stb.commit = 1'b1;
        phaseN     = PH_BUSY;
        busyCntN   = CW'(WRITE_CYCLES - 1);
      end else begin
        stb.bufClear = 1'b1;
        phaseN       = PH_IDLE;
      end
    end else if (startEv) begin
      phaseN       = PH_SEL;
      bitCntN      = '0;
      ackN         = 1'b0;
      txN          = 1'b0;
      stb.bufClear = 1'b1;
    end else if (sclRise) begin
      case (phase)
        PH_SEL, PH_ADDR, PH_WDATA: begin
          if (bitCnt < 4'd8) begin
            stb.shiftIn = 1'b1;
            bitCntN     = bitCnt + 1'b1;
          end else begin
            bitCntN = 4'd9;
          end
        end
        PH_RDATA: begin
          if (bitCnt < 4'd8) bitCntN = bitCnt + 1'b1;
          else if (!sdaLvl) bitCntN = 4'd9;
          else phaseN = PH_HALT;
        end
        default: ;
      endcase
    end else if (sclFall) begin
      case (phase)
        PH_SEL, PH_ADDR, PH_WDATA: begin
          if (bitCnt == 4'd8) begin
            if (phase == PH_SEL) begin
              if (selMatch) begin
                ackN       = 1'b1;
                stb.loadHi = 1'b1;
              end else begin
                phaseN = PH_HALT;
              end
            end else if (phase == PH_ADDR) begin
              ackN        = 1'b1;
              stb.loadLow = 1'b1;
            end else begin
              ackN        = 1'b1;
              stb.bufPush = 1'b1;
            end
          end else if (bitCnt == 4'd9) begin
            ackN    = 1'b0;
            bitCntN = '0;
            if (phase == PH_SEL) begin
              if (selRead) begin
                phaseN     = PH_RDATA;
                stb.loadTx = 1'b1;
                txN        = 1'b1;
              end else begin
                phaseN = PH_ADDR;
              end
            end else begin
              phaseN = PH_WDATA;
            end
          end
        end
        PH_RDATA: begin
          if (bitCnt == 4'd8) begin
            txN = 1'b0;
          end else if (bitCnt == 4'd9) begin
            stb.nextTx = 1'b1;
            txN        = 1'b1;
            bitCntN    = '0;
          end else if (bitCnt != 4'd0) begin
            stb.shiftOut = 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase    <= PH_IDLE;
      bitCnt   <= '0;
      ackDrive <= 1'b0;
      txActive <= 1'b0;
      busyCnt  <= '0;
    end else begin
      phase    <= phaseN;
      bitCnt   <= bitCntN;
      ackDrive <= ackN;
      txActive <= txN;
      busyCnt  <= busyCntN;
    end
  end

  assign sdaOe = ackDrive | (txActive & ~txMsb);
  assign busy  = (phase == PH_BUSY);

endmodule

// File: rtl/twi_mem_data.sv
module twi_mem_data
  import twi_mem_pkg::*;
#(
  parameter int MEM_BYTES = 256,
  parameter int BUF_DEPTH = 8
) (
  input  logic       clk,
  input  logic       rstN,
  input  strobe_t    stb,
  input  logic [2:0] chipEn,
  output logic       selMatch,
  output logic       selRead,
  output logic       txMsb,
  output logic       bufHas
);

  localparam int AW = $clog2(MEM_BYTES);
  localparam int HI = AW - 8;
  localparam int BW = $clog2(BUF_DEPTH + 1);
  localparam int IW = $clog2(BUF_DEPTH);

  logic [7:0]    mem [MEM_BYTES];
  logic [AW-1:0] bufAddr [BUF_DEPTH];
  logic [7:0]    bufData [BUF_DEPTH];
  logic [BW-1:0] bufCnt;
  logic [AW-1:0] ptr, ptrNext, selPtr;
  logic [7:0]    rxShift, txShift;

  // Capacity variant: high pointer bits come from the select byte
  generate
    if (HI > 0) begin : g_hiAddr
      assign selPtr = {rxShift[HI:1], ptr[7:0]};
    end else begin : g_noHi
      assign selPtr = ptr;
    end
  endgenerate

  always_comb begin
    selMatch = (rxShift[7:4] == 4'b1010);
    for (int i = 0; i < 3; i++) begin
      if (i >= HI && rxShift[i+1] != chipEn[i]) selMatch = 1'b0;
    end
  end

  assign ptrNext = ptr + 1'b1;
  assign selRead = rxShift[0];
  assign txMsb   = txShift[7];
  assign bufHas  = (bufCnt != '0);

  always_ff @(posedge clk) begin
    if (!rstN) begin
      for (int i = 0; i < MEM_BYTES; i++) mem[i] <= '0;
      for (int i = 0; i < BUF_DEPTH; i++) begin
        bufAddr[i] <= '0;
        bufData[i] <= '0;
      end
      bufCnt  <= '0;
      ptr     <= '0;
      rxShift <= '0;
      txShift <= '0;
    end else begin
      if (stb.shiftIn) rxShift <= {rxShift[6:0], stb.sdaBit};
      if (stb.loadHi)  ptr <= selPtr;
      if (stb.loadLow) ptr[7:0] <= rxShift;
      if (stb.bufPush) begin
        if (bufCnt < BW'(BUF_DEPTH)) begin
          bufAddr[bufCnt[IW-1:0]] <= ptr;
          bufData[bufCnt[IW-1:0]] <= rxShift;
          bufCnt <= bufCnt + 1'b1;
        end
        ptr <= ptrNext;
      end
      if (stb.bufClear) bufCnt <= '0;
      if (stb.commit) begin
        for (int i = 0; i < BUF_DEPTH; i++) begin
          if (BW'(i) < bufCnt) mem[bufAddr[i]] <= bufData[i];
        end
        bufCnt <= '0;
      end
      if (stb.loadTx) txShift <= mem[ptr];
      if (stb.nextTx) begin
        ptr     <= ptrNext;
        txShift <= mem[ptrNext];
      end
      if (stb.shiftOut) txShift <= {txShift[6:0], 1'b0};
    end
  end

endmodule

// File: rtl/twi_mem_slave.sv
module twi_mem_slave
  import twi_mem_pkg::*;
#(
  parameter int MEM_BYTES    = 256,
  parameter int BUF_DEPTH    = 8,
  parameter int WRITE_CYCLES = 400
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclIn,
  input  logic       sdaIn,
  input  logic [2:0] chipEn,
  output logic       sdaOe,
  output logic       busy
);

  strobe_t stb;
  logic selMatch, selRead, txMsb, bufHas;

  twi_mem_ctrl #(.WRITE_CYCLES(WRITE_CYCLES)) i_ctrl (
    .clk(clk), .rstN(rstN), .sclIn(sclIn), .sdaIn(sdaIn),
    .selMatch(selMatch), .selRead(selRead), .txMsb(txMsb), .bufHas(bufHas),
    .stb(stb), .sdaOe(sdaOe), .busy(busy)
  );

  twi_mem_data #(.MEM_BYTES(MEM_BYTES), .BUF_DEPTH(BUF_DEPTH)) i_data (
    .clk(clk), .rstN(rstN), .stb(stb), .chipEn(chipEn),
    .selMatch(selMatch), .selRead(selRead), .txMsb(txMsb), .bufHas(bufHas)
  );

endmodule

// File: rtl/twi_mem_checks.sv
module twi_mem_checks
  import twi_mem_pkg::*;
#(
  parameter int WRITE_CYCLES = 400
) (
  input logic   clk,
  input logic   rstN,
  input logic   sdaOe,
  input logic   busy,
  input logic   sclLvl,
  input logic   stopEv,
  input phase_t phase
);

  int runCnt;

  always_ff @(posedge clk) begin
    if (!rstN) runCnt <= 0;
    else if (busy) runCnt <= runCnt + 1;
    else runCnt <= 0;
  end

  a_r9_no_ack_busy: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> !sdaOe);

  a_r9_busy_bound: assert property (@(posedge clk) disable iff (!rstN)
    busy |-> runCnt < WRITE_CYCLES);

  a_r9_busy_len: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> runCnt == WRITE_CYCLES);

  a_r5_drive_scl_low: assert property (@(posedge clk) disable iff (!rstN)
    !$stable(sdaOe) |-> !sclLvl);

  a_r7_busy_after_stop: assert property (@(posedge clk) disable iff (!rstN)
    $rose(busy) |-> $past(stopEv));

  a_r2_idle_released: assert property (@(posedge clk) disable iff (!rstN)
    (phase == PH_IDLE) |-> !sdaOe);

endmodule

bind twi_mem_slave twi_mem_checks #(.WRITE_CYCLES(WRITE_CYCLES)) u_checks (
  .clk(clk), .rstN(rstN), .sdaOe(sdaOe), .busy(busy),
  .sclLvl(i_ctrl.sclLvl), .stopEv(i_ctrl.stopEv), .phase(i_ctrl.phase)
);

// File: tb/test_twi_mem_slave.sv
`timescale 1ns/1ps
module test_twi_mem_slave;

  localparam int WC = 400;
  localparam int H  = 8;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic mScl = 1'b1;
  logic mSda = 1'b1;
  logic oeA, oeB, busyA, busyB;
  logic sdaLine;

  int nChecks = 0;
  int nFail = 0;
  int busyRun = 0;
  int lastBusyLen = 0;

  logic [7:0] modelA [256];
  logic [7:0] modelB [512];
  logic [7:0] wbuf [16];
  logic [7:0] rbuf [16];

  always #4 clk = ~clk;

  assign sdaLine = mSda & ~oeA & ~oeB;

  twi_mem_slave #(.MEM_BYTES(256), .BUF_DEPTH(8), .WRITE_CYCLES(WC)) i_twi_mem_slave (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .chipEn(3'b101),
    .sdaOe(oeA), .busy(busyA)
  );

  twi_mem_slave #(.MEM_BYTES(512), .BUF_DEPTH(8), .WRITE_CYCLES(WC)) i_twi_mem_big (
    .clk(clk), .rstN(rstN), .sclIn(mScl), .sdaIn(sdaLine), .chipEn(3'b010),
    .sdaOe(oeB), .busy(busyB)
  );

  always @(negedge clk) begin
    if (busyA) busyRun = busyRun + 1;
    else if (busyRun != 0) begin
      lastBusyLen = busyRun;
      busyRun = 0;
    end
  end

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    nChecks++;
    if (act !== exp) begin
      nFail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bStart();
    mSda = 1'b1; tick(H);
    mScl = 1'b1; tick(H);
    mSda = 1'b0; tick(H);
    mScl = 1'b0; tick(2);
  endtask

  task automatic bStop();
    mSda = 1'b0; tick(H);
    mScl = 1'b1; tick(H);
    mSda = 1'b1; tick(H);
  endtask

  task automatic sendByte(input logic [7:0] b, output bit acked);
    for (int i = 7; i >= 0; i--) begin
      mSda = b[i]; tick(H);
      mScl = 1'b1; tick(H);
      mScl = 1'b0; tick(2);
    end
    mSda = 1'b1; tick(H);
    mScl = 1'b1; tick(H/2);
    acked = (sdaLine == 1'b0);
    tick(H/2);
    mScl = 1'b0; tick(2);
  endtask

  task automatic recvByte(input bit giveAck, output logic [7:0] b);
    mSda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      tick(H);
      mScl = 1'b1; tick(H/2);
      b[i] = sdaLine;
      tick(H/2);
      mScl = 1'b0; tick(2);
    end
    mSda = giveAck ? 1'b0 : 1'b1; tick(H);
    mScl = 1'b1; tick(H);
    mScl = 1'b0; tick(2);
    mSda = 1'b1;
  endtask

  task automatic waitIdle();
    while (busyA || busyB) tick(1);
    tick(4);
  endtask

  task automatic doWrite(input logic [7:0] sel, input logic [7:0] addr, input int n,
                         input bit withStop, output bit ackAll);
    bit a;
    bStart();
    sendByte(sel, a); ackAll = a;
    sendByte(addr, a); ackAll &= a;
    for (int k = 0; k < n; k++) begin
      sendByte(wbuf[k], a); ackAll &= a;
    end
    if (withStop) bStop();
  endtask

  task automatic doRead(input logic [7:0] sel, input logic [7:0] addr, input int n,
                        output bit ackAll);
    bit a;
    bStart();
    sendByte(sel & 8'hFE, a); ackAll = a;
    sendByte(addr, a); ackAll &= a;
    bStart();
    sendByte(sel | 8'h01, a); ackAll &= a;
    for (int k = 0; k < n; k++) recvByte(k != n - 1, rbuf[k]);
    bStop();
  endtask

  // Model update of a committed write: first 8 bytes kept, address wraps
  function automatic void modelWriteA(input logic [7:0] addr, input int n);
    for (int k = 0; k < n && k < 8; k++) modelA[8'(addr + 8'(k))] = wbuf[k];
  endfunction

  function automatic logic [7:0] expA(input logic [7:0] addr, input int k);
    return modelA[8'(addr + 8'(k))];
  endfunction

  initial begin
    repeat (190000) @(posedge clk);
    nChecks++; nFail++;
    $display("FAIL watchdog expired");
    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

  initial begin
    bit ok;
    logic [7:0] b;
    for (int i = 0; i < 256; i++) modelA[i] = 8'h00;
    for (int i = 0; i < 512; i++) modelB[i] = 8'h00;
    void'($urandom(32'd20240611));

    tick(5);
    check("R12 sdaOe at reset", {31'd0, oeA}, 0);
    check("R12 busy at reset", {31'd0, busyA}, 0);
    rstN = 1'b1;
    tick(5);

    // R1: select pattern clocked without any start
    sendByte(8'hAA, ok);
    check("R1 no ack without start", {31'd0, ok}, 0);
    bStop();

    // R3: matching write select is acknowledged; R2: silent after stop
    bStart();
    sendByte(8'hAA, ok);
    check("R3 select ack", {31'd0, ok}, 1);
    bStop();
    sendByte(8'hAA, ok);
    check("R2 no ack after stop", {31'd0, ok}, 0);
    bStop();
    check("R7 no write cycle without data", {31'd0, busyA}, 0);

    // R4: wrong chip enable, wrong type, then bytes ignored until start
    bStart();
    sendByte(8'hAC, ok);
    check("R4 chip enable mismatch", {31'd0, ok}, 0);
    sendByte(8'hAA, ok);
    check("R4 ignored until start", {31'd0, ok}, 0);
    bStop();
    bStart();
    sendByte(8'hBA, ok);
    check("R4 type mismatch", {31'd0, ok}, 0);
    bStop();

    // R6/R9: write of three bytes, busy window
    wbuf[0] = 8'h3C; wbuf[1] = 8'hA5; wbuf[2] = 8'h81;
    doWrite(8'hAA, 8'h10, 3, 1'b1, ok);
    check("R6 write acks", {31'd0, ok}, 1);
    check("R9 busy after stop", {31'd0, busyA}, 1);
    bStart();
    sendByte(8'hAA, ok);
    check("R9 no ack while busy", {31'd0, ok}, 0);
    bStop();
    waitIdle();
    check("R9 busy length", lastBusyLen, WC);
    modelWriteA(8'h10, 3);
    doRead(8'hAA, 8'h10, 3, ok);
    check("R10 read acks", {31'd0, ok}, 1);
    for (int k = 0; k < 3; k++) check("R10 R5 read data", rbuf[k], expA(8'h10, k));

    // R12: untouched byte reads zero
    doRead(8'hAA, 8'h80, 1, ok);
    check("R12 array cleared", rbuf[0], 8'h00);

    // R7: repeated start discards pending data
    wbuf[0] = 8'h77;
    doWrite(8'hAA, 8'h20, 1, 1'b0, ok);
    doRead(8'hAA, 8'h20, 1, ok);
    check("R7 repeated start discards", rbuf[0], expA(8'h20, 0));
    check("R7 no busy after discard", lastBusyLen, WC);

    // R8: ten bytes into an eight-entry queue
    for (int k = 0; k < 10; k++) wbuf[k] = 8'h50 + 8'(k);
    doWrite(8'hAA, 8'h40, 10, 1'b1, ok);
    check("R8 overflow bytes acked", {31'd0, ok}, 1);
    waitIdle();
    modelWriteA(8'h40, 10);
    doRead(8'hAA, 8'h40, 10, ok);
    for (int k = 0; k < 10; k++) check("R8 queue depth", rbuf[k], expA(8'h40, k));

    // R6: pointer wrap at the array end
    for (int k = 0; k < 4; k++) wbuf[k] = 8'hE0 + 8'(k);
    doWrite(8'hAA, 8'hFE, 4, 1'b1, ok);
    waitIdle();
    modelWriteA(8'hFE, 4);
    doRead(8'hAA, 8'hFE, 4, ok);
    for (int k = 0; k < 4; k++) check("R6 wrap", rbuf[k], expA(8'hFE, k));

    // R10: no-acknowledge leaves the pointer in place
    doRead(8'hAA, 8'h11, 1, ok);
    bStart();
    sendByte(8'hAB, ok);
    recvByte(1'b0, b);
    bStop();
    check("R10 pointer kept after nack", b, expA(8'h11, 0));

    // R11: 512-byte slave, select bit 1 is address bit 8
    wbuf[0] = 8'h9D; wbuf[1] = 8'h2E;
    doWrite(8'hA6, 8'h33, 2, 1'b1, ok);
    check("R11 big slave write acks", {31'd0, ok}, 1);
    check("R11 other slave not busy", {31'd0, busyA}, 0);
    waitIdle();
    modelB[9'h133] = 8'h9D; modelB[9'h134] = 8'h2E;
    doRead(8'hA4, 8'h33, 2, ok);
    check("R11 low page", rbuf[0], modelB[9'h033]);
    doRead(8'hA6, 8'h33, 2, ok);
    check("R11 high page b0", rbuf[0], modelB[9'h133]);
    check("R11 high page b1", rbuf[1], modelB[9'h134]);

    // Random writes and read-back
    for (int it = 0; it < 5; it++) begin
      logic [7:0] addr;
      int n;
      addr = 8'($urandom % 256);
      n = 1 + int'($urandom % 8);
      for (int k = 0; k < n; k++) wbuf[k] = 8'($urandom);
      doWrite(8'hAA, addr, n, 1'b1, ok);
      check("R6 random write acks", {31'd0, ok}, 1);
      waitIdle();
      modelWriteA(addr, n);
      doRead(8'hAA, addr, n, ok);
      for (int k = 0; k < n; k++) check("R10 random read", rbuf[k], expA(addr, k));
    end

    $display("%0d/%0d checks passed", nChecks - nFail, nChecks);
    $finish;
  end

endmodule